// File: doc/BRIEF.md
# Private Per-Core Countdown Timer

This block is a 32-bit down-counter that a processor core programs through four word-wide registers inside a 32-byte window. Software writes a start value, picks a prescale divisor, and chooses between one-shot and periodic operation. Each time the count runs out, a sticky event flag is raised. That flag, gated by an interrupt-enable bit, drives one level-sensitive interrupt line until software clears the flag by writing a 1 to it.

The counter steps down once every P+1 cycles of the block clock, where P is an 8-bit field in the control word. A count of zero is treated as idle: the timer does nothing until software writes a nonzero value. In periodic mode, running out refills the counter from the load register on the same edge that sets the flag. In one-shot mode, running out leaves the counter at zero.

Reads are combinational from the address and byte lanes presented in the same cycle. Writes take effect at the next rising clock edge.

Top module: `private_countdown_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Only accesses with `acc_be` = 4'hF and `acc_addr[1:0]` = 0 are accepted. Other writes change nothing, and other reads return 0. Slot `acc_addr[4:2]`: 0 = load, 1 = counter, 2 = control, 3 = flag. Slots 4 to 7 read 0.
- R3: Control layout: bit 0 is run, bit 1 is periodic, bit 2 is interrupt enable, and bits 15:8 are the divisor P. All 32 bits read back as written. Bits 31:16 and 7:3 have no effect.
- R4: A write to the load slot sets both the load value and the counter. A write to the counter slot sets only the counter. Either write restarts the prescale phase.
- R5: While run is set and the count is nonzero, the count drops by one on every (P+1)-th edge after the last phase restart. Starting from N, it runs out (P+1)*N edges after the restarting write.
- R6: A count of zero never runs out, even with run set, and the flag stays clear.
- R7: A control write with run = 1 while run is already set and the count is nonzero leaves the count untouched. Any other control write with run = 1 restarts the phase, and if periodic = 1 in the written value, it also copies the load value into the counter.
- R8: Clearing run freezes the count. The counter slot reads 0 whenever run is clear or the count is 0.
- R9: Running out sets the flag. In periodic mode the counter is refilled from load on that same edge; in one-shot mode it becomes 0.
- R10: `irq` is high exactly when the flag is set and control bit 2 is set.
- R11: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If running out and a clear fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_addr | input | 5 | Byte offset inside the 32-byte window |
| acc_be | input | 4 | Byte lane enables; only 4'hF is accepted |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the presented address |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The embedded properties check, on every cycle, the properties that can be stated locally:
- the step-by-one decrement;
- the refill or zeroing on run-out;
- that the flag is set on run-out and cleared by a lone clear;
- phase advance;
- that a prescale tick is never issued at a zero count;
- that a repeated start leaves the count unchanged.

Only the bench scenarios can show the end-to-end timing, by sweeping the divisor and start count and comparing the counter and flag against (P+1)*N arithmetic edge by edge. The same applies to register layout and readback, rejection of partial and unaligned accesses, the freeze on stop, and the run-out-versus-clear collision.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int REG_W   = 32;
    localparam int DIV_W   = 8;
    localparam int WIN_AW  = 5;
    localparam int SLOT_W  = WIN_AW - 2;
    localparam logic [3:0] FULL_BE = 4'hF;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_LOAD  = 3'd0,
        SLOT_COUNT = 3'd1,
        SLOT_CTRL  = 3'd2,
        SLOT_FLAG  = 3'd3
    } slot_e;

    typedef struct packed {
        logic [REG_W-17:0] spare_hi;
        logic [DIV_W-1:0]  div;
        logic [4:0]        spare_lo;
        logic              irq_en;
        logic              periodic;
        logic              run;
    } ctrl_t;

    typedef struct packed {
        logic wr_load;
        logic wr_count;
        logic wr_ctrl;
        logic wr_flag;
    } wr_sel_t;

    function automatic logic access_ok(input logic [WIN_AW-1:0] addr,
                                       input logic [3:0] be);
        return (be == FULL_BE) && (addr[1:0] == 2'b00);
    endfunction

    function automatic wr_sel_t decode_wr(input logic wr,
                                          input logic [WIN_AW-1:0] addr,
                                          input logic [3:0] be);
        wr_sel_t s;
        logic    ok;
        ok = wr && access_ok(addr, be);
        s.wr_load  = ok && (addr[WIN_AW-1:2] == SLOT_LOAD);
        s.wr_count = ok && (addr[WIN_AW-1:2] == SLOT_COUNT);
        s.wr_ctrl  = ok && (addr[WIN_AW-1:2] == SLOT_CTRL);
        s.wr_flag  = ok && (addr[WIN_AW-1:2] == SLOT_FLAG);
        return s;
    endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          restart,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] phase;

    assign tick = active && (phase >= div);

    always_ff @(posedge clk) begin
        if (rst || restart || !active || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    // R5: phase advances by one between ticks while nothing restarts it
    p_phase_step_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !restart && !tick) |=> (phase == $past(phase) + PW'(1)));

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          periodic,
    input  logic [CW-1:0] reload_val,
    input  logic          set_en,
    input  logic [CW-1:0] set_val,
    input  logic          clr_req,
    output logic [CW-1:0] cnt,
    output logic          flag,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    assign expire = tick && !set_en && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (set_en) begin
            cnt <= set_val;
        end else if (expire) begin
            cnt <= periodic ? reload_val : '0;
        end else if (tick) begin
            cnt <= cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // R6: the prescaler never ticks on an idle (zero) count
    p_no_tick_idle_r6: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt != '0));

    // R5: an ordinary tick steps the count down by one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_en && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

    // R9: periodic run-out refills from load
    p_refill_r9: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> (cnt == $past(reload_val)));

    // R9: one-shot run-out leaves zero
    p_oneshot_r9: assert property (@(posedge clk) disable iff (rst)
        (expire && !periodic) |=> (cnt == '0));

    // R9 / R11: run-out sets the flag even against a clear
    p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    // R11: a lone clear drops the flag
    p_flag_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !expire) |=> !flag);

    // R8: without tick or write the count holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !set_en) |=> $stable(cnt));

endmodule

// File: rtl/private_countdown_timer.sv
module private_countdown_timer
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_wr,
    input  logic [WIN_AW-1:0] acc_addr,
    input  logic [3:0]        acc_be,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    output logic              irq
);
    ctrl_t              ctrl_q;
    ctrl_t              ctrl_new;
    logic [REG_W-1:0]   load_q;
    logic [REG_W-1:0]   cnt;
    logic               flag;
    logic               expire;
    logic               tick;
    logic               active;
    logic               start;
    logic               restart;
    logic               set_en;
    logic [REG_W-1:0]   set_val;
    logic               clr_req;
    wr_sel_t            ws;

    assign ws       = decode_wr(acc_wr, acc_addr, acc_be);
    assign ctrl_new = ctrl_t'(acc_wdata);
    assign active   = ctrl_q.run && (cnt != '0);

    // a start is any run=1 control write that does not hit a running count
    assign start    = ws.wr_ctrl && ctrl_new.run && !active;
    assign restart  = ws.wr_load || ws.wr_count || start;
    assign set_en   = ws.wr_load || ws.wr_count || (start && ctrl_new.periodic);
    assign set_val  = ws.wr_ctrl ? load_q : acc_wdata;
    assign clr_req  = ws.wr_flag && acc_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (ws.wr_load) load_q <= acc_wdata;
            if (ws.wr_ctrl) ctrl_q <= ctrl_new;
        end
    end

    ptmr_prescale #(.PW(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .restart (restart),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    ptmr_count #(.CW(REG_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .periodic   (ctrl_q.periodic),
        .reload_val (load_q),
        .set_en     (set_en),
        .set_val    (set_val),
        .clr_req    (clr_req),
        .cnt        (cnt),
        .flag       (flag),
        .expire     (expire)
    );

    always_comb begin
        acc_rdata = '0;
        if (access_ok(acc_addr, acc_be)) begin
            case (acc_addr[WIN_AW-1:2])
                SLOT_LOAD:  acc_rdata = load_q;
                SLOT_COUNT: acc_rdata = active ? cnt : '0;
                SLOT_CTRL:  acc_rdata = ctrl_q;
                SLOT_FLAG:  acc_rdata = {{(REG_W-1){1'b0}}, flag};
                default:    acc_rdata = '0;
            endcase
        end
    end

    assign irq = flag && ctrl_q.irq_en;

    // R7: repeated start on a running nonzero count leaves the count alone
    p_restart_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (ws.wr_ctrl && ctrl_new.run && ctrl_q.run && cnt != '0 && !tick)
        |=> (cnt == $past(cnt)));

    // R2: a rejected write leaves load and control unchanged
    p_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_be != FULL_BE) |=> ($stable(load_q) && $stable(ctrl_q)));

endmodule

// File: tb/sim_private_countdown_timer.sv
`timescale 1ns/1ps
module sim_private_countdown_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [3:0]  acc_be = 4'hF;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_LOAD = 5'h00;
    localparam logic [4:0] A_CNT  = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_FLAG = 5'h0C;

    always #2.5 clk = ~clk;

    private_countdown_timer u0 (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_be = be;
        @(posedge clk);
        #0.5;
        acc_wr = 1'b0; acc_be = 4'hF;
    endtask

    // combinational read; caller places it after a negedge
    task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        acc_addr = a; acc_be = be;
        #0.5;
        d = acc_rdata;
        acc_be = 4'hF;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        rd(A_LOAD, d); check("R1 load", d, 0);
        rd(A_CNT,  d); check("R1 count", d, 0);
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_FLAG, d); check("R1 flag", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R3 readback of every control bit, run left clear
        wr(A_CTRL, 32'hA5A5_5AFE);
        @(negedge clk);
        rd(A_CTRL, d); check("R3 ctrl readback", d, 32'hA5A5_5AFE);
        rd(A_CTRL, d, 4'h3); check("R2 partial read", d, 0);
        rd(5'h10, d); check("R2 slot4 read", d, 0);
        rd(5'h1C, d); check("R2 slot7 read", d, 0);
        rd(5'h0A, d); check("R2 unaligned read", d, 0);
        wr(A_CTRL, 32'h0);

        // R2 partial and unaligned writes ignored
        wr(A_LOAD, 32'h1234, 4'h3);
        wr(5'h02, 32'h55);
        @(negedge clk);
        rd(A_LOAD, d); check("R2 rejected write", d, 0);

        // R4 counter write leaves load alone; R8 disabled read is 0
        wr(A_LOAD, 32'd9);
        wr(A_CNT, 32'd7);
        @(negedge clk);
        rd(A_LOAD, d); check("R4 load kept", d, 9);
        rd(A_CNT, d);  check("R8 count read while stopped", d, 0);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        rd(A_CNT, d); check("R4 counter value 7 kept", d, 7);
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd9);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        rd(A_CNT, d); check("R4 load write sets counter", d, 9);
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1);

        // R5/R9 sweep: one-shot, divisor P, start N
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 5; n++) begin
                if (n == 4) continue;
                wr(A_CTRL, 32'h0);
                wr(A_FLAG, 32'h1);
                wr(A_CTRL, (p << 8) | 32'h1);
                wr(A_CNT, n);
                for (int k = 1; k <= (p + 1) * n + 2; k++) begin
                    int ec;
                    @(posedge clk);
                    @(negedge clk);
                    ec = n - k / (p + 1);
                    if (ec < 0) ec = 0;
                    rd(A_CNT, d);  check("R5 count step", d, ec);
                    rd(A_FLAG, d); check("R9 flag at run-out", d, (k >= (p + 1) * n) ? 1 : 0);
                end
            end
        end

        // R9/R10/R11 periodic refill and interrupt
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h0000_0107);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, d); check("R9 flag before run-out", d, 0);
        rd(A_CNT, d);  check("R5 count before run-out", d, 1);
        check("R10 irq low", {31'b0, irq}, 0);
        @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, d); check("R9 flag after run-out", d, 1);
        rd(A_CNT, d);  check("R9 periodic refill", d, 3);
        check("R10 irq high", {31'b0, irq}, 1);
        wr(A_FLAG, 32'h0);
        @(negedge clk);
        rd(A_FLAG, d); check("R11 write 0 no effect", d, 1);
        wr(A_FLAG, 32'h1);
        @(negedge clk);
        rd(A_FLAG, d); check("R11 write 1 clears", d, 0);
        check("R10 irq follows flag", {31'b0, irq}, 0);
        // R10 gating by enable bit
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0000_0003);
        wr(A_CNT, 32'd1);
        @(negedge clk);
        @(negedge clk);
        rd(A_FLAG, d); check("R10 flag set, irq disabled", d, 1);
        check("R10 irq gated off", {31'b0, irq}, 0);

        // R7 repeated start ignored
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, 32'h0000_0703);
        wr(A_CNT, 32'd20);
        repeat (2) @(posedge clk);
        wr(A_CTRL, 32'h0000_0703);
        @(negedge clk);
        rd(A_CNT, d); check("R7 repeated start keeps count", d, 20);

        // R6 zero count never runs out
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, d); check("R6 idle flag", d, 0);
        rd(A_CNT, d);  check("R6 idle count", d, 0);

        // R8 stop freezes the count
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd50);
        wr(A_CTRL, 32'h1);
        repeat (5) @(posedge clk);
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        rd(A_CNT, d); check("R8 stopped read", d, 0);
        repeat (10) @(posedge clk);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        rd(A_CNT, d); check("R8 frozen count resumes", d, 44);

        // R11 run-out wins over same-edge clear
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1);
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd4);
        repeat (3) @(posedge clk);
        wr(A_FLAG, 32'h1);
        @(negedge clk);
        rd(A_FLAG, d); check("R11 run-out beats clear", d, 1);
        rd(A_CNT, d);  check("R9 one-shot ends at zero", d, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule